// File: doc/BRIEF.md
# Serial Status Byte Shifter

This block answers a status request on the slave side of a serial peripheral link. A one-cycle pulse on `cmd_start` arms it. Once the master pulls chip select low, it presents a fixed table of status bytes on the slave data output, one bit for each serial clock. The serial clock and chip select come from outside and have no timing relation to the system clock. Both pass through a synchronizer chain before any decision uses them. The block acts only on a rising edge of the synchronized serial clock, so each serial clock period moves the stream on by exactly one bit.

The table holds eighteen bytes and is computed when the design is elaborated. Bytes leave from the highest index down to index 0, and each byte goes out most significant bit first. A bit index and a byte index count down to their terminal values. When the last bit of byte 0 has been clocked, the block goes back to waiting for a new request.

Top module: `status_shifter`

## Requirements
- R1: After reset, and while no request has been accepted, `spi_miso` is 0 whatever `spi_sclk` and `spi_cs_n` do.
- R2: After a request, the block holds until the synchronized `spi_cs_n` is low. Serial clock edges seen before then move neither index, so the first bit sent is still bit 7 of byte 17.
- R3: Every rising edge of the synchronized `spi_sclk` during a transfer advances exactly one bit. Bytes are sent in the order 17, 16, …, 0, each MSB (bit 7) first, for 144 bits in total. The bit for an edge is valid on `spi_miso` before that edge.
- R4: Byte i of the table is (37·i + 5) mod 256 for i = 0..13. Bytes 14 and 15 are 0xFF. Bytes 16 and 17 are 0x00.
- R5: The edge that takes bit 0 of byte 0 ends the transfer. `spi_miso` then returns to 0, later serial clocks have no effect, and a new request starts a complete fresh transfer from byte 17.
- R6: `spi_miso` is 0 in every state except the one that presents a bit, including while the block waits for chip select.
- R7: A `cmd_start` pulse during a transfer has no effect. The stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| cmd_start | input | 1 | One-cycle status request pulse, synchronous to `clk` |
| spi_sclk | input | 1 | Serial clock from the master, asynchronous |
| spi_cs_n | input | 1 | Active-low chip select from the master, asynchronous |
| spi_miso | output | 1 | Serial status data to the master |

## Verification
A corrupted bit or byte index shows up at the port as a wrong bit within a single serial clock, and the bench compares every reassembled byte against the arithmetic table. A state machine that skips or repeats an edge shifts the bit alignment of every byte that follows, and the first byte that is not uniform exposes it. A fault in the end condition shows up within one byte time after the 144th bit, either as a truncated stream or as `spi_miso` still driven after the end.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CS,
    ST_SHIFT,
    ST_NEXT_BIT,
    ST_NEXT_BYTE
  } ssr_state_e;

  // Table content: the last two entries are clear, the two before them are
  // all ones, and the rest follow an affine sequence.
  function automatic logic [BYTE_W-1:0] status_entry(input int idx, input int count);
    logic [BYTE_W-1:0] val;
    if (idx >= count - 2)       val = '0;
    else if (idx >= count - 4)  val = '1;
    else                        val = BYTE_W'(idx * 37 + 5);
    return val;
  endfunction

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssr_down_counter.sv
module ssr_down_counter #(
  parameter int unsigned W        = 3,
  parameter int unsigned LOAD_VAL = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         at_zero
);
  always_ff @(posedge clk) begin
    if (!rst_n)     value <= W'(LOAD_VAL);
    else if (load)  value <= W'(LOAD_VAL);
    else if (step)  value <= value - W'(1);
  end

  assign at_zero = (value == '0);
endmodule

// File: rtl/status_shifter.sv
module status_shifter
  import ssr_pkg::*;
#(
  parameter int unsigned NUM_BYTES   = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  output logic spi_miso
);
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam int unsigned WORD_W = $clog2(NUM_BYTES);

  // Synchronized serial inputs
  logic sclk_s, cs_n_s, sclk_q, sclk_rise;

  ssr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));

  ssr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(spi_cs_n), .q(cs_n_s));

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;

  // Sequencer
  ssr_state_e state, state_nx;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] word_idx;
  logic bit_term, word_term;
  logic bit_load, bit_step, word_load, word_step;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (cmd_start) state_nx = ST_WAIT_CS;
      ST_WAIT_CS: if (!cs_n_s)   state_nx = ST_SHIFT;
      ST_SHIFT: begin
        if (sclk_rise) begin
          if (bit_term && word_term) state_nx = ST_IDLE;
          else if (bit_term)         state_nx = ST_NEXT_BYTE;
          else                       state_nx = ST_NEXT_BIT;
        end
      end
      ST_NEXT_BIT:  state_nx = ST_SHIFT;
      ST_NEXT_BYTE: state_nx = ST_SHIFT;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    bit_load  = 1'b0;
    bit_step  = 1'b0;
    word_load = 1'b0;
    word_step = 1'b0;
    case (state)
      ST_IDLE, ST_WAIT_CS: begin
        bit_load  = 1'b1;
        word_load = 1'b1;
      end
      ST_NEXT_BIT:  bit_step = 1'b1;
      ST_NEXT_BYTE: begin
        bit_load  = 1'b1;
        word_step = 1'b1;
      end
      default: ;
    endcase
  end

  ssr_down_counter #(.W(BIT_W), .LOAD_VAL(BYTE_W - 1)) u_bit_cnt (
    .clk(clk), .rst_n(rst_n), .load(bit_load), .step(bit_step),
    .value(bit_idx), .at_zero(bit_term));

  ssr_down_counter #(.W(WORD_W), .LOAD_VAL(NUM_BYTES - 1)) u_word_cnt (
    .clk(clk), .rst_n(rst_n), .load(word_load), .step(word_step),
    .value(word_idx), .at_zero(word_term));

  // Status table, computed at elaboration
  logic [BYTE_W-1:0] table_q [NUM_BYTES];
  logic [BYTE_W-1:0] cur_byte;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_table
    assign table_q[g] = status_entry(g, NUM_BYTES);
  end

  always_comb begin
    cur_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (word_idx == WORD_W'(i)) cur_byte = table_q[i];
  end

  assign spi_miso = (state == ST_SHIFT) ? cur_byte[bit_idx] : 1'b0;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
#(
  parameter int unsigned BW = 3,
  parameter int unsigned WW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_start,
  input logic          spi_miso,
  input ssr_state_e    state,
  input logic          sclk_rise,
  input logic          cs_n_s,
  input logic [BW-1:0] bit_idx,
  input logic [WW-1:0] word_idx,
  input logic          bit_term,
  input logic          word_term
);
  // R6
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SHIFT) |-> !spi_miso);

  // R2
  wait_for_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_CS && cs_n_s) |=> (state == ST_WAIT_CS));

  // R3
  hold_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && !sclk_rise) |=> (state == ST_SHIFT && $stable(bit_idx) && $stable(word_idx)));

  // R3
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT_BIT) |=> (bit_idx == BW'($past(bit_idx) - 1) && $stable(word_idx)));

  // R3
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NEXT_BYTE) |=> (bit_idx == '1 && word_idx == WW'($past(word_idx) - 1)));

  // R5
  end_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && sclk_rise && bit_term && word_term) |=> (state == ST_IDLE));

  // R7
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && cmd_start && !sclk_rise) |=> (state == ST_SHIFT));
endmodule

bind status_shifter ssr_checker #(.BW(BIT_W), .WW(WORD_W)) u_ssr_checker (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .spi_miso(spi_miso),
  .state(state), .sclk_rise(sclk_rise), .cs_n_s(cs_n_s),
  .bit_idx(bit_idx), .word_idx(word_idx), .bit_term(bit_term), .word_term(word_term));

// File: tb/status_shifter_test.sv
`timescale 1ns/1ps
module status_shifter_test;
  localparam int NB = 18;

  logic clk = 1'b0, rst_n = 1'b0, cmd_start = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso;
  int checks = 0, fails = 0;

  status_shifter uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  function automatic logic [7:0] expect_byte(input int i);
    if (i == 16 || i == 17) return 8'h00;
    if (i == 14 || i == 15) return 8'hFF;
    return 8'((i * 37 + 5) % 256);
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic pulse_cmd();
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
  endtask

  // Toggle sclk n times and report whether miso was ever high.
  task automatic idle_clocks(input int n, input int half, output logic seen);
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      #(half) seen |= spi_miso; spi_sclk = 1'b1;
      #(half) seen |= spi_miso; spi_sclk = 1'b0;
    end
  endtask

  task automatic transfer(input int half, input bit inject, input string tag);
    logic [7:0] got;
    logic seen;
    spi_cs_n = 1'b0;
    #(half);
    for (int b = NB - 1; b >= 0; b--) begin
      got = '0;
      for (int i = 7; i >= 0; i--) begin
        if (inject && b == 9 && i == 4) pulse_cmd(); // R7
        #(half);
        got[i] = spi_miso;
        spi_sclk = 1'b1;
        #(half) spi_sclk = 1'b0;
      end
      if (b >= 14) check("R4", got, expect_byte(b), $sformatf("%s byte %0d", tag, b));
      else         check("R3", got, expect_byte(b), $sformatf("%s byte %0d", tag, b));
    end
    #100;
    check("R5", {7'd0, spi_miso}, 8'h00, {tag, " miso after last bit"});
    idle_clocks(4, half, seen);
    check("R5", {7'd0, seen}, 8'h00, {tag, " miso after end with extra sclk"});
    spi_cs_n = 1'b1;
    #50;
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic seen;
    #3;
    repeat (4) @(negedge clk);
    check("R1", {7'd0, spi_miso}, 8'h00, "miso during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {7'd0, spi_miso}, 8'h00, "miso after reset");
    idle_clocks(10, 37, seen);
    spi_cs_n = 1'b0;
    idle_clocks(6, 37, seen);
    spi_cs_n = 1'b1;
    check("R1", {7'd0, seen}, 8'h00, "miso with no request");

    // R2 / R6: request, edges while chip select is still high
    pulse_cmd();
    idle_clocks(5, 53, seen);
    check("R6", {7'd0, seen}, 8'h00, "miso while waiting for chip select");
    transfer(73, 1'b0, "R2 first");

    // R5: fresh transfers at other rates
    pulse_cmd();
    transfer(41, 1'b0, "fast");
    pulse_cmd();
    transfer(129, 1'b0, "slow");

    // R7: request pulse in the middle of a transfer
    pulse_cmd();
    transfer(67, 1'b1, "R7 inject");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule